// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter with Selectable Framing

This block turns 16-bit audio samples into a serial audio stream. Samples are written into an eight-entry transmit queue. At the start of every frame the engine takes a group of one or two samples from the queue. It then shifts them out, most significant bit first, on a data line. A bit clock and a frame clock frame the stream. A low normal frame clock marks the left slot (slot 0) and a high one marks the right slot (slot 1). Each slot lasts `HALF_BITS` bit clocks, 20 by default.

The framing is chosen at run time: standard I2S, left-justified or right-justified. Each of the two clocks can be inverted at its pin, and the two inversions are independent. As clock master, the block derives the bit clock from its own clock and drives both clock pins. As slave, it follows a bit clock and a frame clock supplied from outside. A channel-count field and a per-slot index map decide which sample of the group goes into each slot. A data-request output asks for refills in bursts of four. A sample counter and a sticky underrun flag report progress and starvation. The serial stream is copied onto four data lines, and each line has its own output enable.

Top module: `aud_tx_port`

## Requirements
- R1: `fmt_sel` picks the framing. 0 is I2S: the sample MSB is at bit position 1 of the slot. 1 is left-justified: the MSB is at position 0. 2 is right-justified: the LSB is at position `HALF_BITS-1`. 3 sends only zeros. Positions that carry no sample bit are 0.
- R2: The clock pins equal the normal clock level XOR `bclk_inv` (bit clock) and XOR `fclk_inv` (frame clock). Data changes only after a falling edge of the normal bit clock. A normal frame clock of 0 carries slot 0, the left slot.
- R3: With `role_slave`=0, both clock enables are 1 and the bit clock period is 2*`BCLK_DIV` clock cycles (4 by default). With `role_slave`=1, both clock enables are 0 and timing follows `bclk_in` and `fclk_in`.
- R4: While `glb_en`=0, the normal bit clock is held at 0, the normal frame clock at 1 and the data lines at 0. After `glb_en` rises, the first slot sent is a left slot.
- R5: While `tx_en`=0, nothing is taken from the queue, no sample is counted and the data lines stay 0. Shifting begins at the next left-slot start.
- R6: Data line i carries the stream when `line_oe[i]`=1 and is 0 otherwise.
- R7: `chan_m1` holds the number of active slots minus one. Each frame takes `chan_m1`+1 samples from the queue. A slot whose number is at or above that count sends zeros.
- R8: Slot n sends the group sample whose index is `slot_map[4n+3:4n]`. An index at or above the active count sends zeros.
- R9: The queue holds 8 samples, and a write while it is full is dropped. `flush` empties the queue and clears the underrun flag.
- R10: If the queue holds fewer samples than the active count at a frame start, that whole frame sends zeros, nothing is taken from the queue, and `underrun` is set and stays set.
- R11: `tx_count` increases by one at the start of each active slot that sends a loaded sample. `cnt_clr` sets it to zero.
- R12: `drq` is 1 exactly when `drq_en`=1 and the queue has at least 4 free entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| glb_en | input | 1 | Enables the whole block |
| tx_en | input | 1 | Enables shifting of samples |
| role_slave | input | 1 | 0 = drive clocks, 1 = follow external clocks |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified |
| bclk_inv | input | 1 | Inverts the bit clock at the pin |
| fclk_inv | input | 1 | Inverts the frame clock at the pin |
| chan_m1 | input | 1 | Active slots minus one |
| slot_map | input | 8 | 4-bit sample index for each slot |
| line_oe | input | 4 | Output enable for each data line |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 16 | Sample to queue |
| flush | input | 1 | Empties the queue and clears underrun |
| cnt_clr | input | 1 | Clears the sample counter |
| drq_en | input | 1 | Enables data requests |
| bclk_in | input | 1 | External bit clock (slave) |
| fclk_in | input | 1 | External frame clock (slave) |
| bclk_out | output | 1 | Bit clock pin |
| bclk_oe | output | 1 | Bit clock pin drive enable |
| fclk_out | output | 1 | Frame clock pin |
| fclk_oe | output | 1 | Frame clock pin drive enable |
| sdo | output | 4 | Serial data lines |
| drq | output | 1 | Data request, at least 4 entries free |
| underrun | output | 1 | Sticky queue starvation flag |
| tx_count | output | 32 | Samples sent |

## Verification
The embedded assertions check properties on every cycle. The queue level never exceeds its depth, and a full queue ignores writes. The engine never takes more samples than the queue holds. Serial data changes only on a falling-edge event of the bit clock. Starved frames emit zeros, the underrun flag stays set until a flush, and each counted sample adds exactly one. The bench scenarios cover what a property cannot see: that each framing places the sample at the right bit positions, that inversion and slot mapping land the right word in the right slot, the master bit-clock period, slave tracking, and the sample order through a queue that has dropped a write.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SMP_W  = 16;
  localparam int IDX_W  = $clog2(SMP_W);
  localparam int NSLOT  = 2;
  localparam int CHW    = $clog2(NSLOT);
  localparam int NACT_W = $clog2(NSLOT + 1);
  localparam int MAP_W  = 4;

  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_NONE  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // slot position of the sample MSB, -1 when the format sends nothing
  function automatic int msb_pos(fmt_e f, int half_len);
    case (f)
      FMT_STD:   return 1;
      FMT_LEFT:  return 0;
      FMT_RIGHT: return half_len - SMP_W;
      default:   return -1;
    endcase
  endfunction

  // which sample bit (if any) sits at a slot position
  function automatic pick_t bit_pick(fmt_e f, int pos, int half_len);
    pick_t p;
    int    st;
    st    = msb_pos(f, half_len);
    p.hit = 1'b0;
    p.idx = '0;
    if (st >= 0 && pos >= st && pos < st + SMP_W) begin
      p.hit = 1'b1;
      p.idx = IDX_W'(SMP_W - 1 - (pos - st));
    end
    return p;
  endfunction
endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo
  import aud_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        wr_en,
  input  logic [SMP_W-1:0]            wr_data,
  input  logic [NACT_W-1:0]           pop_cnt,
  output logic [NSLOT-1:0][SMP_W-1:0] heads,
  output logic [LW-1:0]               level
);
  localparam int AW = $clog2(DEPTH);

  logic [SMP_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [LW-1:0]    lvl_q;
  logic             wr_acc;

  assign wr_acc = wr_en && (lvl_q < LW'(DEPTH));
  assign level  = lvl_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_head
    assign heads[i] = mem[rp_q + AW'(i)];
  end

  always_ff @(posedge clk) begin
    if (wr_acc && !flush) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_q + AW'(wr_acc);
      rp_q  <= rp_q + AW'(pop_cnt);
      lvl_q <= lvl_q + LW'(wr_acc) - LW'(pop_cnt);
    end
  end

  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LW'(DEPTH) && wr_en && pop_cnt == '0 && !flush) |=> lvl_q == LW'(DEPTH));
  a_r10_no_overpop: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(pop_cnt) <= lvl_q);
endmodule

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slave,
  input  logic bclk_inv,
  input  logic fclk_inv,
  input  logic bclk_pin,
  input  logic fclk_pin,
  output logic bclk_gen,
  output logic fclk_ext,
  output logic fall_evt
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_q;
  logic          bq;
  logic [1:0]    bsync_q, fsync_q;
  logic          bprev_q;
  logic          bnorm_s;
  logic          tick, fall_m, fall_s;

  assign tick     = (div_q == CW'(DIV - 1));
  assign fall_m   = run && !slave && tick && bq;
  assign bnorm_s  = bsync_q[1] ^ bclk_inv;
  assign fall_s   = run && slave && bprev_q && !bnorm_s;
  assign fall_evt = fall_m || fall_s;
  assign bclk_gen = bq;
  assign fclk_ext = fsync_q[1] ^ fclk_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bq    <= 1'b0;
    end else if (!run || slave) begin
      div_q <= '0;
      bq    <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      bq    <= !bq;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync_q <= '0;
      fsync_q <= '0;
      bprev_q <= 1'b0;
    end else begin
      bsync_q <= {bsync_q[0], bclk_pin};
      fsync_q <= {fsync_q[0], fclk_pin};
      bprev_q <= bnorm_s;
    end
  end

  // R3: every master falling edge of the bit clock is announced as an event
  a_r3_fall_announced: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !slave && $past(run) && $past(!slave) && $fell(bq)) |-> $past(fall_evt));
  a_r3_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave |-> !bq);
endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter
  import aud_tx_pkg::*;
#(
  parameter int HALF_BITS = 20,
  parameter int LW        = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        tx_en,
  input  logic                        slave,
  input  logic [1:0]                  fmt,
  input  logic [CHW-1:0]              chan,
  input  logic [NSLOT*MAP_W-1:0]      map,
  input  logic                        fall_evt,
  input  logic                        fclk_ext,
  input  logic [LW-1:0]               level,
  input  logic [NSLOT-1:0][SMP_W-1:0] heads,
  output logic                        sdo_bit,
  output logic                        fclk_norm,
  output logic [NACT_W-1:0]           pop_cnt,
  output logic                        sample_evt,
  output logic                        uflow_evt
);
  localparam int PW = $clog2(HALF_BITS);
  localparam logic [PW-1:0] LAST = PW'(HALF_BITS - 1);

  logic [PW-1:0]               pos_q, pos_n;
  logic                        half_q, half_n;
  logic                        act_q, act_n;
  logic                        ok_q, ok_n;
  logic [NACT_W-1:0]           nact_q, nact_n, nact_in;
  logic [NSLOT*MAP_W-1:0]      map_q, map_n;
  logic [NSLOT-1:0][SMP_W-1:0] grp_q, grp_n;
  logic                        sdo_q, bit_n;
  logic                        edge_new, left_start, load;
  logic [MAP_W-1:0]            sel;
  logic [SMP_W-1:0]            word;
  pick_t                       pick;

  assign nact_in = NACT_W'(chan) + 1'b1;

  always_comb begin
    if (slave) begin
      edge_new = (fclk_ext != half_q);
      half_n   = fclk_ext;
      pos_n    = edge_new ? '0 : ((pos_q == LAST) ? pos_q : pos_q + 1'b1);
    end else begin
      edge_new = (pos_q == LAST);
      half_n   = edge_new ? !half_q : half_q;
      pos_n    = edge_new ? '0 : pos_q + 1'b1;
    end
    left_start = fall_evt && edge_new && !half_n;
    load       = left_start && tx_en && (level >= LW'(nact_in));
    uflow_evt  = left_start && tx_en && !load;
    pop_cnt    = load ? nact_in : '0;
    act_n      = left_start ? tx_en : act_q;
    ok_n       = left_start ? load : ok_q;
    nact_n     = left_start ? nact_in : nact_q;
    map_n      = left_start ? map : map_q;
    grp_n      = load ? heads : grp_q;

    sel  = map_n[int'(half_n)*MAP_W +: MAP_W];
    word = '0;
    if (act_n && ok_n && (int'(half_n) < int'(nact_n)) && (int'(sel) < int'(nact_n)))
      word = grp_n[sel[CHW-1:0]];
    pick  = bit_pick(fmt_e'(fmt), int'(pos_n), HALF_BITS);
    bit_n = pick.hit && word[pick.idx];

    sample_evt = fall_evt && edge_new && act_n && ok_n && (int'(half_n) < int'(nact_n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= LAST;
      half_q <= 1'b1;
      act_q  <= 1'b0;
      ok_q   <= 1'b0;
      nact_q <= NACT_W'(1);
      map_q  <= '0;
      grp_q  <= '0;
      sdo_q  <= 1'b0;
    end else if (!run) begin
      pos_q  <= LAST;
      half_q <= 1'b1;
      act_q  <= 1'b0;
      ok_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (fall_evt) begin
      pos_q  <= pos_n;
      half_q <= half_n;
      act_q  <= act_n;
      ok_q   <= ok_n;
      nact_q <= nact_n;
      map_q  <= map_n;
      grp_q  <= grp_n;
      sdo_q  <= bit_n;
    end
  end

  assign sdo_bit   = sdo_q;
  assign fclk_norm = half_q;

  a_r2_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(fall_evt)) |-> $stable(sdo_q));
  a_r2_frame_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(fall_evt)) |-> $stable(half_q));
  a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sdo_q);
  a_r10_starved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && uflow_evt) |=> !sdo_q);
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> (half_q && !sdo_q));
endmodule

// File: rtl/aud_tx_port.sv
module aud_tx_port
  import aud_tx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HALF_BITS = 20,
  parameter int BCLK_DIV  = 2,
  parameter int NLINES    = 4,
  parameter int CNT_W     = 32,
  parameter int BURST     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   glb_en,
  input  logic                   tx_en,
  input  logic                   role_slave,
  input  logic [1:0]             fmt_sel,
  input  logic                   bclk_inv,
  input  logic                   fclk_inv,
  input  logic [CHW-1:0]         chan_m1,
  input  logic [NSLOT*MAP_W-1:0] slot_map,
  input  logic [NLINES-1:0]      line_oe,
  input  logic                   wr_en,
  input  logic [SMP_W-1:0]       wr_data,
  input  logic                   flush,
  input  logic                   cnt_clr,
  input  logic                   drq_en,
  input  logic                   bclk_in,
  input  logic                   fclk_in,
  output logic                   bclk_out,
  output logic                   bclk_oe,
  output logic                   fclk_out,
  output logic                   fclk_oe,
  output logic [NLINES-1:0]      sdo,
  output logic                   drq,
  output logic                   underrun,
  output logic [CNT_W-1:0]       tx_count
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [NSLOT-1:0][SMP_W-1:0] heads;
  logic [LW-1:0]               level;
  logic [NACT_W-1:0]           pop_cnt;
  logic                        bclk_gen, fclk_ext, fall_evt;
  logic                        sdo_bit, fclk_norm;
  logic                        sample_evt, uflow_evt;
  logic                        urun_q;
  logic [CNT_W-1:0]            cnt_q;

  aud_tx_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .pop_cnt(pop_cnt), .heads(heads), .level(level)
  );

  aud_tx_clkgen #(.DIV(BCLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(glb_en), .slave(role_slave),
    .bclk_inv(bclk_inv), .fclk_inv(fclk_inv), .bclk_pin(bclk_in), .fclk_pin(fclk_in),
    .bclk_gen(bclk_gen), .fclk_ext(fclk_ext), .fall_evt(fall_evt)
  );

  aud_tx_shifter #(.HALF_BITS(HALF_BITS), .LW(LW)) u_shf (
    .clk(clk), .rst_n(rst_n), .run(glb_en), .tx_en(tx_en), .slave(role_slave),
    .fmt(fmt_sel), .chan(chan_m1), .map(slot_map), .fall_evt(fall_evt),
    .fclk_ext(fclk_ext), .level(level), .heads(heads), .sdo_bit(sdo_bit),
    .fclk_norm(fclk_norm), .pop_cnt(pop_cnt), .sample_evt(sample_evt),
    .uflow_evt(uflow_evt)
  );

  assign bclk_out = bclk_gen ^ bclk_inv;
  assign fclk_out = fclk_norm ^ fclk_inv;
  assign bclk_oe  = !role_slave;
  assign fclk_oe  = !role_slave;
  assign drq      = drq_en && ((LW'(DEPTH) - level) >= LW'(BURST));

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign sdo[i] = sdo_bit && line_oe[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urun_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (flush)          urun_q <= 1'b0;
      else if (uflow_evt) urun_q <= 1'b1;
      if (cnt_clr)         cnt_q <= '0;
      else if (sample_evt) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign underrun = urun_q;
  assign tx_count = cnt_q;

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_q && !flush) |=> urun_q);
  a_r10_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urun_q) |-> $past(uflow_evt));
  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !cnt_clr) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_evt && !cnt_clr) |=> $stable(cnt_q));
endmodule

// File: tb/tb_aud_tx_port.sv
module tb_aud_tx_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 0, tx_en = 0, role_slave = 0, bclk_inv = 0, fclk_inv = 0;
  logic [1:0] fmt_sel = 0;
  logic [0:0] chan_m1 = 1;
  logic [7:0] slot_map = 8'h10;
  logic [3:0] line_oe = 4'b0101;
  logic wr_en = 0, flush = 0, cnt_clr = 0, drq_en = 0;
  logic [15:0] wr_data = 0;
  logic sb_n = 1'b1, sf_n = 1'b1, slave_run = 1'b0;
  logic bclk_in, fclk_in;
  logic bclk_out, bclk_oe, fclk_out, fclk_oe, drq, underrun;
  logic [3:0] sdo;
  logic [31:0] tx_count;

  assign bclk_in = sb_n ^ bclk_inv;
  assign fclk_in = sf_n ^ fclk_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_tx_port dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tx_en(tx_en), .role_slave(role_slave),
    .fmt_sel(fmt_sel), .bclk_inv(bclk_inv), .fclk_inv(fclk_inv), .chan_m1(chan_m1),
    .slot_map(slot_map), .line_oe(line_oe), .wr_en(wr_en), .wr_data(wr_data),
    .flush(flush), .cnt_clr(cnt_clr), .drq_en(drq_en), .bclk_in(bclk_in),
    .fclk_in(fclk_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fclk_out(fclk_out),
    .fclk_oe(fclk_oe), .sdo(sdo), .drq(drq), .underrun(underrun), .tx_count(tx_count)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fields: fmt, binv, finv, chan, map, sample0, sample1, left, right
  typedef struct packed {
    logic [1:0] f; logic bi; logic fi; logic ch; logic [7:0] mp;
    logic [15:0] s0; logic [15:0] s1; logic [15:0] el; logic [15:0] er;
  } vec_t;
  localparam logic [76:0] VECS [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 8'h10, 16'hA5C3, 16'h1234, 16'hA5C3, 16'h1234},
    {2'd1, 1'b1, 1'b0, 1'b1, 8'h10, 16'h8001, 16'h7FFE, 16'h8001, 16'h7FFE},
    {2'd2, 1'b0, 1'b1, 1'b1, 8'h10, 16'hFFFF, 16'h0001, 16'hFFFF, 16'h0001},
    {2'd0, 1'b1, 1'b1, 1'b1, 8'h01, 16'h1111, 16'hEEEE, 16'hEEEE, 16'h1111},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'h10, 16'hBEEF, 16'h0000, 16'hBEEF, 16'h0000},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'h00, 16'hC0DE, 16'h5A5A, 16'hC0DE, 16'hC0DE},
    {2'd3, 1'b0, 1'b0, 1'b1, 8'h10, 16'h1234, 16'h4321, 16'h0000, 16'h0000},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'h11, 16'hBEEF, 16'h0000, 16'h0000, 16'h0000}
  };

  // expected slot contents, first bit sent at the MSB end
  function automatic logic [HALF-1:0] shape(input logic [1:0] f, input logic [15:0] w);
    logic [HALF-1:0] full;
    full = {w, {(HALF-16){1'b0}}};
    case (f)
      2'd0: return full >> 1;
      2'd1: return full;
      2'd2: return HALF'(w);
      default: return '0;
    endcase
  endfunction

  // serial capture
  logic mon_on = 0, started = 0, prev_b = 0;
  int nb = 0, nh = 0, oe_bad = 0;
  logic [HALF-1:0] vec = '0;
  logic [HALF-1:0] halves [16];
  logic lvl [16];

  always @(negedge clk) begin
    logic bn, fn;
    bn = (role_slave ? bclk_in : bclk_out) ^ bclk_inv;
    fn = (role_slave ? fclk_in : fclk_out) ^ fclk_inv;
    if (!mon_on) begin
      started = 0; nb = 0; nh = 0; prev_b = bn;
    end else begin
      if (bn && !prev_b) begin
        if (!started && !fn) started = 1;
        if (started && nh < 16) begin
          vec = {vec[HALF-2:0], sdo[0]};
          if (nb == 0) lvl[nh] = fn;
          nb++;
          if (nb == HALF) begin halves[nh] = vec; nh++; nb = 0; end
        end
      end
      prev_b = bn;
      if (sdo[1] || sdo[3] || (sdo[2] != sdo[0])) oe_bad++;
    end
  end

  // external clock source for slave mode
  initial begin
    forever begin
      @(negedge clk);
      if (slave_run) begin
        for (int h = 0; h < 2; h++) begin
          for (int p = 0; p < HALF; p++) begin
            sb_n = 1'b0; sf_n = h[0];
            repeat (6) @(negedge clk);
            sb_n = 1'b1;
            repeat (6) @(negedge clk);
          end
        end
      end
    end
  end

  task automatic write_word(input logic [15:0] w);
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
  endtask

  task automatic stop_all();
    @(negedge clk); glb_en = 0; tx_en = 0; mon_on = 0; slave_run = 0;
    sb_n = 1'b1; sf_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic start_all();
    @(negedge clk); glb_en = 1; tx_en = 1; mon_on = 1;
  endtask

  task automatic measure_period(output int n);
    logic pb, cb;
    n = 0;
    @(negedge clk); pb = bclk_out ^ bclk_inv;
    forever begin
      @(negedge clk); cb = bclk_out ^ bclk_inv;
      if (cb && !pb) break;
      pb = cb;
    end
    pb = cb;
    forever begin
      @(negedge clk); n++; cb = bclk_out ^ bclk_inv;
      if (cb && !pb) break;
      pb = cb;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int per;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // reset and idle state (R4, R3, R12, R11, R10)
    chk(bclk_out == 1'b0, "R4 idle bclk", 32'(bclk_out), 0);
    chk(fclk_out == 1'b1, "R4 idle fclk", 32'(fclk_out), 1);
    chk(sdo == 4'b0, "R4 idle data", 32'(sdo), 0);
    chk(bclk_oe && fclk_oe, "R3 master drives clocks", 32'({bclk_oe, fclk_oe}), 3);
    chk(drq == 1'b0, "R12 drq off", 32'(drq), 0);
    chk(tx_count == 0, "R11 reset count", tx_count, 0);
    chk(underrun == 1'b0, "R10 reset flag", 32'(underrun), 0);

    // vector table (R1 R2 R7 R8 R10 R11)
    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VECS[i]);
      stop_all();
      fmt_sel = v.f; bclk_inv = v.bi; fclk_inv = v.fi; chan_m1 = v.ch; slot_map = v.mp;
      pulse_flush();
      pulse_clr();
      chk(underrun == 1'b0, "R9 flush clears underrun", 32'(underrun), 0);
      chk(bclk_out == v.bi && fclk_out == !v.fi, "R2 idle pins follow inversion",
          32'({bclk_out, fclk_out}), 32'({v.bi, !v.fi}));
      write_word(v.s0);
      if (v.ch) write_word(v.s1);
      start_all();
      wait (nh >= 3);
      @(negedge clk);
      chk(halves[0] == shape(v.f, v.el), "R1 R8 left slot", 32'(halves[0]), 32'(shape(v.f, v.el)));
      chk(halves[1] == shape(v.f, v.er), "R1 R7 right slot", 32'(halves[1]), 32'(shape(v.f, v.er)));
      chk(lvl[0] == 1'b0 && lvl[1] == 1'b1, "R2 left on low frame clock",
          32'({lvl[0], lvl[1]}), 32'h1);
      chk(halves[2] == '0, "R10 starved frame zero", 32'(halves[2]), 0);
      chk(underrun == 1'b1, "R10 underrun set", 32'(underrun), 1);
      chk(tx_count == 32'(v.ch) + 1, "R11 count per sample", tx_count, 32'(v.ch) + 1);
      if (i == 0) begin
        measure_period(per);
        chk(per == 4, "R3 bit clock period", 32'(per), 4);
      end
    end
    chk(oe_bad == 0, "R6 line enables", 32'(oe_bad), 0);

    // R9: ninth write dropped, order preserved
    stop_all();
    fmt_sel = 2'd1; bclk_inv = 0; fclk_inv = 0; chan_m1 = 1; slot_map = 8'h10;
    pulse_flush();
    for (int k = 0; k < 9; k++) write_word(16'h3000 + 16'(k * 16'h0111));
    start_all();
    wait (nh >= 10);
    @(negedge clk);
    chk(halves[7] == shape(2'd1, 16'h3777), "R9 last kept sample", 32'(halves[7]), 32'(shape(2'd1, 16'h3777)));
    chk(halves[8] == '0, "R9 full write dropped", 32'(halves[8]), 0);

    // R5: no shifting while transmit is off
    stop_all();
    pulse_flush();
    pulse_clr();
    write_word(16'h1357); write_word(16'h2468);
    @(negedge clk); glb_en = 1; mon_on = 1;
    repeat (400) @(negedge clk);
    chk(tx_count == 0, "R5 nothing counted", tx_count, 0);
    chk(underrun == 1'b0, "R5 no starvation", 32'(underrun), 0);
    chk(halves[0] == '0 && halves[1] == '0, "R5 data line quiet", 32'(halves[0]), 0);
    @(negedge clk); tx_en = 1;
    repeat (500) @(negedge clk);
    chk(tx_count == 2, "R5 starts at next frame", tx_count, 2);

    // R4: disable returns pins to idle
    @(negedge clk); glb_en = 0;
    repeat (3) @(negedge clk);
    chk(bclk_out == 1'b0 && fclk_out == 1'b1 && sdo == 4'b0, "R4 disable idles pins",
        32'({bclk_out, fclk_out, sdo}), 32'h10);

    // R12: data request follows free space
    stop_all();
    pulse_flush();
    @(negedge clk); drq_en = 1;
    @(negedge clk);
    chk(drq == 1'b1, "R12 empty queue requests", 32'(drq), 1);
    for (int k = 0; k < 4; k++) write_word(16'(k));
    chk(drq == 1'b1, "R12 four free requests", 32'(drq), 1);
    write_word(16'h0005);
    chk(drq == 1'b0, "R12 three free no request", 32'(drq), 0);
    @(negedge clk); drq_en = 0;
    @(negedge clk);
    chk(drq == 1'b0, "R12 disabled", 32'(drq), 0);

    // R3: slave mode follows external clocks
    stop_all();
    role_slave = 1; fmt_sel = 2'd1; bclk_inv = 0; fclk_inv = 1; chan_m1 = 1; slot_map = 8'h10;
    pulse_flush();
    write_word(16'h9ABC); write_word(16'h4321);
    @(negedge clk);
    chk(!bclk_oe && !fclk_oe, "R3 slave releases clocks", 32'({bclk_oe, fclk_oe}), 0);
    start_all();
    slave_run = 1;
    wait (nh >= 2);
    @(negedge clk);
    chk(halves[0] == shape(2'd1, 16'h9ABC), "R3 slave left", 32'(halves[0]), 32'(shape(2'd1, 16'h9ABC)));
    chk(halves[1] == shape(2'd1, 16'h4321), "R3 slave right", 32'(halves[1]), 32'(shape(2'd1, 16'h4321)));
    stop_all();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule